// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a station-management master that talks to external PHYs over a two-wire management bus (clock MDC, bidirectional data MDIO). Software prepares one 32-bit command word holding the start code, the opcode, the port address, a 5-bit register-or-device address and a 16-bit data value, and writes it with bit 31 set. The controller then emits one complete management frame and keeps bit 31 of the readback word at 1 until that frame has finished.

The start code and opcode bits go onto the wire exactly as software wrote them. This makes one shift engine cover both addressing schemes. Legacy direct-register frames use start code 01. Extended frames use start code 00, and for them software writes the 16-bit register number first with an address-set opcode, waits for the busy bit to clear, and then issues the write or read frame. For read opcodes the controller releases MDIO from the turnaround onward and returns the PHY's 16 data bits in the low half of the readback word.

MDC is derived from the system clock. The half period is worked out from the system clock rate and the maximum management clock rate. Outside a frame MDC stays low.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the readback word is 0, MDC is low and MDIO is not driven (mdio_oe = 0). Whenever bit 31 of the readback word is 0, MDC stays low and mdio_oe stays 0.
- R2: A command write with bit 31 = 1 while idle starts a frame and sets readback bit 31 from the next cycle. A write with bit 31 = 0 only stores bits 30:0, and no frame follows.
- R3: A frame is 64 bit times, sent MSB first. It consists of 32 ones, then start code (command bits 17:16), opcode (bits 19:18), port address (bits 24:20), register/device address (bits 29:25), two turnaround bits, and 16 data bits.
- R4: When opcode bit 19 is 0 (00 address-set, 01 write), the controller drives all 64 bits. The turnaround is 1 then 0, and the data bits are command bits 15:0.
- R5: When opcode bit 19 is 1 (10 legacy read, 11 extended read), mdio_oe is 0 for bit times 46 to 63. The controller samples mdio_i on each rising MDC edge of bit times 48 to 63 and, when the frame ends, places those bits (first sampled = bit 15) in readback bits 15:0.
- R6: MDC is high and low for HALF_CYC system clocks each, with HALF_CYC = ceil(SYS_CLK_KHZ / (2*MDC_MAX_KHZ)). This is 50 at the defaults (250 MHz in, 2.5 MHz out). MDIO changes only when MDC falls.
- R7: Readback bit 31 returns to 0 exactly 128*HALF_CYC cycles after the launching write. This is the falling MDC edge that closes bit time 63.
- R8: A command write while bit 31 of the readback word is 1 has no effect: the frame on the wire continues unchanged and the stored fields keep their values.
- R9: The start code and opcode are sent verbatim, so both start code 01 frames and start code 00 frames (including opcode 00 and 11) come from the same engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word; bit 31 launches a frame |
| cmd_rdata | output | 32 | Readback: busy, spare bit 30, stored fields, data/read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pin |

## Verification
The hardest case to reach is a command write arriving mid-frame, in particular during a read whose turnaround has released the line. Only a bench that knows when a frame is in flight can place that write. The stimulus fires a second, different command partway through an extended read. The bench then checks that the whole waveform, the returned data and the stored fields all still match the first command. Read data comes from a responder that follows the bench's own bit-time model, so a bit-order or sampling-edge error shows up as wrong readback data.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    typedef struct packed {
        logic        spare;
        logic [4:0]  regad;
        logic [4:0]  phyad;
        logic [1:0]  op;
        logic [1:0]  st;
        logic [15:0] data;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = run && (st_q.cnt == CW'(HALF_CYC - 1));
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc       = st_q.mdc;
    assign rise_tick = wrap && !st_q.mdc;
    assign fall_tick = wrap && st_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  mdio_cmd_t   cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    localparam int IW = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  active;
        logic                  rd;
        logic [IW-1:0]         idx;
        logic [FRAME_BITS-1:0] sh;
        logic [15:0]           rdat;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (launch && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.rd     = cmd.op[1];
            st_d.idx    = '0;
            st_d.rdat   = '0;
            st_d.sh     = {32'hFFFF_FFFF, cmd.st, cmd.op, cmd.phyad, cmd.regad,
                           (cmd.op[1] ? 2'b11 : 2'b10), cmd.data};
        end else if (st_q.active) begin
            if (rise_tick && st_q.rd && (int'(st_q.idx) >= DATA_POS))
                st_d.rdat = {st_q.rdat[14:0], mdio_i};
            if (fall_tick) begin
                if (int'(st_q.idx) == FRAME_BITS - 1) begin
                    st_d.active = 1'b0;
                    done        = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign mdio_o  = st_q.sh[FRAME_BITS-1];
    assign mdio_oe = st_q.active && !(st_q.rd && (int'(st_q.idx) >= TA_POS));
    assign rd_data = st_q.rdat;
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int SYS_CLK_KHZ = 250000,
    parameter int MDC_MAX_KHZ = 2500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int HALF_CYC = (SYS_CLK_KHZ + 2*MDC_MAX_KHZ - 1) / (2*MDC_MAX_KHZ);

    typedef struct packed {
        logic      busy;
        mdio_cmd_t cmd;
    } top_st_t;

    top_st_t     st_d, st_q;
    mdio_cmd_t   wr_cmd;
    logic        launch, eng_active, eng_done, rise_tick, fall_tick;
    logic [15:0] eng_rdata;

    assign wr_cmd = mdio_cmd_t'(cmd_wdata[30:0]);
    assign launch = cmd_wr && !st_q.busy && cmd_wdata[31];

    always_comb begin
        st_d = st_q;
        if (cmd_wr && !st_q.busy) begin
            st_d.cmd  = wr_cmd;
            st_d.busy = cmd_wdata[31];
        end
        if (eng_done) begin
            st_d.busy = 1'b0;
            if (st_q.cmd.op[1]) st_d.cmd.data = eng_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_rdata = {st_q.busy, st_q.cmd};

    mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) mdc_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd       (wr_cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (eng_active),
        .done      (eng_done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (eng_rdata)
    );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk #(
    parameter int HALF_CYC = 50
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_wdata,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic        busy;
    logic [31:0] busy_cyc_q;

    assign busy = cmd_rdata[31];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cyc_q <= '0;
        else if (!busy) busy_cyc_q <= '0;
        else            busy_cyc_q <= busy_cyc_q + 1;
    end

    // R1: idle bus is quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R2: accepted launch sets busy
    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[31] && !busy) |=> busy);

    // R4: non-read frames keep the line driven throughout
    p_write_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_rdata[19]) |-> mdio_oe);

    // R6: data moves only on the falling MDC edge
    p_data_stable_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc) && mdio_oe && $past(mdio_oe)) |-> $stable(mdio_o));

    // R7: frame length measured from launch
    p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cyc_q == 32'(128 * HALF_CYC)));

    // R8: stored fields frozen during a frame
    p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_rdata[30:16]));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.HALF_CYC(HALF_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_master_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb_top;
    localparam int H = 50;          // 250 MHz / (2 * 2.5 MHz)
    localparam int FRAME_CYC = 128 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #2 clk = ~clk;

    mdio_cmd_master dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit          m_active = 0;
    bit          m_rd = 0;
    int          m_t = 0;
    logic [63:0] m_frame = '0;
    logic [15:0] resp = 16'h0000;
    int          bad_cnt = 0;
    string       bad_msg = "";

    function automatic logic [63:0] build_frame(logic [31:0] w);
        return {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25],
                (w[19] ? 2'b11 : 2'b10), w[15:0]};
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (m_active) begin
                m_t++;
                if (m_t == FRAME_CYC) m_active = 0;
            end else if (cmd_wr && cmd_wdata[31]) begin
                m_active = 1;
                m_rd     = cmd_wdata[19];
                m_frame  = build_frame(cmd_wdata);
                m_t      = 0;
            end
        end
    end

    always @(negedge clk) begin
        int  k;
        bit  e_mdc, e_oe;
        k     = m_t / (2 * H);
        e_mdc = m_active && (((m_t / H) % 2) == 1);
        e_oe  = m_active && !(m_rd && k >= 46);
        mdio_i <= (m_active && m_rd && k >= 48) ? resp[63 - k] : 1'b1;
        if (rst_n) begin
            if (mdc !== e_mdc || mdio_oe !== e_oe || cmd_rdata[31] !== m_active ||
                (e_oe && mdio_o !== m_frame[63 - k])) begin
                if (bad_cnt == 0)
                    bad_msg = $sformatf("t=%0d mdc=%b/%b oe=%b/%b busy=%b/%b o=%b/%b",
                        m_t, mdc, e_mdc, mdio_oe, e_oe, cmd_rdata[31], m_active,
                        mdio_o, m_frame[63 - k]);
                bad_cnt++;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_wave(string req);
        n_checks++;
        if (bad_cnt != 0) begin
            n_fail++;
            $display("FAIL %s waveform mismatches=%0d first: %s (actual/expected)",
                     req, bad_cnt, bad_msg);
        end
        bad_cnt = 0;
    endtask

    task automatic issue(logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (cmd_rdata[31]) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(bit go, logic [1:0] st, logic [1:0] op,
                                       logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
        return {go, 1'b0, ra, pa, op, st, d};
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] w, w2;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 readback", cmd_rdata, 32'h0);
        check("R1 mdc/oe", {30'h0, mdc, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: store without launch
        w = mk(0, 2'b01, 2'b01, 5'd9, 5'd4, 16'h5A5A);
        issue(w);
        repeat (3 * H) @(negedge clk);
        check("R2 store-only readback", cmd_rdata, w);
        check_wave("R2 no frame for bit31=0");

        // R3 R4 R6 R7: legacy write
        w = mk(1, 2'b01, 2'b01, 5'd5, 5'h0D, 16'hA5C3);
        issue(w);
        check("R2 busy after launch", {31'h0, cmd_rdata[31]}, 32'h1);
        wait_idle();
        check_wave("R3 R4 R6 R7 legacy write frame");
        check("R4 fields after write", cmd_rdata, {1'b0, w[30:0]});

        // R5: legacy read
        resp = 16'h1234;
        w = mk(1, 2'b01, 2'b10, 5'h1F, 5'd2, 16'h0000);
        issue(w);
        wait_idle();
        check_wave("R5 legacy read frame");
        check("R5 legacy read data", {16'h0, cmd_rdata[15:0]}, 32'h1234);

        // R9: extended address-set, write
        w = mk(1, 2'b00, 2'b00, 5'd3, 5'd1, 16'h0100);
        issue(w);
        wait_idle();
        check_wave("R9 extended address frame");
        check("R9 address fields", cmd_rdata, {1'b0, w[30:0]});
        w = mk(1, 2'b00, 2'b01, 5'd3, 5'd1, 16'h8001);
        issue(w);
        wait_idle();
        check_wave("R9 extended write frame");

        // R8 + R5 + R9: extended read with an ignored mid-frame write
        resp = 16'hBEEF;
        w  = mk(1, 2'b00, 2'b11, 5'd3, 5'd1, 16'h0000);
        w2 = mk(1, 2'b01, 2'b01, 5'd17, 5'd30, 16'h7777);
        issue(w);
        repeat (100 * H) @(negedge clk);
        issue(w2);
        wait_idle();
        check_wave("R8 R5 extended read waveform with mid-frame write");
        check("R5 extended read data", {16'h0, cmd_rdata[15:0]}, 32'hBEEF);
        check("R8 fields unchanged", {16'h0, cmd_rdata[31:16]}, {16'h0, 1'b0, w[30:16]});
        repeat (4 * H) @(negedge clk);
        check_wave("R1 idle after frames");
        check("R1 idle mdc/oe", {30'h0, mdc, mdio_oe}, 32'h0);
        finish_run();
    end
endmodule